// File: doc/BRIEF.md
# Processor Clock Idle Controller

This block decides, cycle by cycle, whether the processor core clock may run. Software requests idle mode by writing a one-cycle stop pulse. The block does not stop the clock at once. It waits until the core reports, through a one-cycle retire handshake, that the instruction in flight has finished, and only then drops the processor clock enable. While idle, any interrupt source that is enabled in either the fast class or the normal class turns the clock back on at the next edge. A reset also turns it back on.

The clock enable is a register output, so the gate cell that follows it only sees changes at clock edges. A status bit reports the real gated state, not the state that was requested. The enable for the system bus clock, which other bus masters use, is held high at all times and is never gated by this block.

Top module: `pclk_idle_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, `pclk_en` is 1 and `pclk_off` is 0 after that edge.
- R2: A stop pulse (`stop_wr`=1) sampled while running, with no enabled interrupt pending, starts a drain phase in which `pclk_en` stays 1. `insn_done` sampled in the same cycle as the stop pulse does not count toward the drain.
- R3: While draining, `insn_done`=1 makes `pclk_en` 0 and `pclk_off` 1 after the next edge.
- R4: While idle, a source i with `irq_req[i]` & `fast_en[i]` (fast class) or `irq_req[i]` & `norm_en[i]` (normal class) makes `pclk_en` 1 after the next edge.
- R5: An interrupt request whose source has no enable bit set in either class leaves an idle clock stopped.
- R6: An enabled interrupt sampled while draining cancels the stop, even when `insn_done` is 1 in the same cycle. The block returns to running, and a later `insn_done` does not stop the clock.
- R7: A stop pulse sampled in the same cycle as an enabled interrupt while running is dropped. The clock stays on, and a later `insn_done` does not stop it.
- R8: A stop pulse sampled while draining or idle has no effect on the clock.
- R9: `bus_clk_en` is 1 in every cycle, including reset and idle.
- R10: `pclk_off` is 1 exactly when `pclk_en` is 0.
- R11: A reset sampled while idle restores `pclk_en` to 1 after that edge, and the block is then running, not draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst | input | 1 | Synchronous active-high system reset |
| stop_wr | input | 1 | Write-one pulse that requests idle mode |
| insn_done | input | 1 | Core handshake: in-flight instruction has retired |
| irq_req | input | N_IRQ | Interrupt request per source |
| fast_en | input | N_IRQ | Per-source enable, fast class |
| norm_en | input | N_IRQ | Per-source enable, normal class |
| pclk_en | output | 1 | Registered processor clock enable |
| pclk_off | output | 1 | Status: processor clock currently gated |
| bus_clk_en | output | 1 | Bus master clock enable, always asserted |

## Verification
Two of the block's functions can collide in one cycle. A stop request can meet a wake in the running state, and a wake can meet the retire handshake in the drain state. The bench drives each pair on the same negative edge. It checks that the clock is still enabled after that edge. It then sends one more `insn_done` and checks that the clock still runs, which shows that no stop request is left pending.

// File: rtl/pclk_idle_pkg.sv
package pclk_idle_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_IDLE  = 2'd2
    } idle_state_e;

    typedef struct packed {
        logic fast;
        logic norm;
    } wake_t;

    typedef struct packed {
        logic stop;
        logic done;
    } core_evt_t;

    function automatic logic wake_any(input wake_t w);
        return w.fast | w.norm;
    endfunction

    function automatic idle_state_e idle_next(input idle_state_e cur,
                                              input wake_t       w,
                                              input core_evt_t   ev);
        idle_state_e nxt;
        nxt = cur;
        case (cur)
            ST_RUN:   if (ev.stop && !wake_any(w)) nxt = ST_DRAIN;
            ST_DRAIN: if (wake_any(w))             nxt = ST_RUN;
                      else if (ev.done)            nxt = ST_IDLE;
            ST_IDLE:  if (wake_any(w))             nxt = ST_RUN;
            default:                               nxt = ST_RUN;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/pclk_wake_detect.sv
module pclk_wake_detect
    import pclk_idle_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] fast_en,
    input  logic [N_IRQ-1:0] norm_en,
    output wake_t            wake
);
    logic [N_IRQ-1:0] fast_hit;
    logic [N_IRQ-1:0] norm_hit;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_src
        assign fast_hit[i] = irq_req[i] & fast_en[i];
        assign norm_hit[i] = irq_req[i] & norm_en[i];
    end

    assign wake.fast = |fast_hit;
    assign wake.norm = |norm_hit;

    // R5: a request with no enable bit set cannot raise a wake
    always_comb begin
        if ((irq_req & (fast_en | norm_en)) == '0)
            p_masked_silent_r5: assert (!wake_any(wake));
    end
endmodule

// File: rtl/pclk_idle_fsm.sv
module pclk_idle_fsm
    import pclk_idle_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wake_t     wake,
    input  core_evt_t ev,
    output logic      pclk_en,
    output logic      pclk_off
);
    idle_state_e state_q, state_d;

    always_comb state_d = idle_next(state_q, wake, ev);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RUN;
            pclk_en  <= 1'b1;
            pclk_off <= 1'b0;
        end else begin
            state_q  <= state_d;
            pclk_en  <= (state_d != ST_IDLE);
            pclk_off <= (state_d == ST_IDLE);
        end
    end

    // R1: reset forces the clock on
    p_reset_on_r1: assert property (@(posedge clk) rst |=> pclk_en);

    // R3: the clock only falls right after a retire handshake
    p_fall_on_done_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(pclk_en) |-> $past(ev.done));

    // R2: draining keeps the clock running
    p_drain_runs_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN) |-> pclk_en);

    // R4: any enabled wake leaves the clock on after the edge
    p_wake_on_r4: assert property (@(posedge clk) disable iff (rst)
        wake_any(wake) |=> pclk_en);

    // R5: idle without a wake stays idle
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !wake_any(wake)) |=> !pclk_en);

    // R10: status tracks the real gate
    p_status_r10: assert property (@(posedge clk) disable iff (rst)
        pclk_off != pclk_en);
endmodule

// File: rtl/pclk_idle_ctrl.sv
module pclk_idle_ctrl
    import pclk_idle_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_wr,
    input  logic             insn_done,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] fast_en,
    input  logic [N_IRQ-1:0] norm_en,
    output logic             pclk_en,
    output logic             pclk_off,
    output logic             bus_clk_en
);
    wake_t     wake;
    core_evt_t ev;

    assign ev.stop = stop_wr;
    assign ev.done = insn_done;

    pclk_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .irq_req (irq_req),
        .fast_en (fast_en),
        .norm_en (norm_en),
        .wake    (wake)
    );

    pclk_idle_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wake     (wake),
        .ev       (ev),
        .pclk_en  (pclk_en),
        .pclk_off (pclk_off)
    );

    // R9: other bus masters never lose their clock
    assign bus_clk_en = 1'b1;

    // R7: a stop that meets a wake while the clock runs leaves it running
    p_stop_wake_r7: assert property (@(posedge clk) disable iff (rst)
        (pclk_en && stop_wr && wake_any(wake)) |=> pclk_en);
endmodule

// File: tb/sim_pclk_idle_ctrl.sv
module sim_pclk_idle_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst, stop_wr, insn_done;
    logic [N-1:0] irq_req, fast_en, norm_en;
    logic         pclk_en, pclk_off, bus_clk_en;

    typedef struct {
        logic  en;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   ended  = 0;

    always #2 clk = ~clk;

    pclk_idle_ctrl #(.N_IRQ(N)) u0 (
        .clk(clk), .rst(rst), .stop_wr(stop_wr), .insn_done(insn_done),
        .irq_req(irq_req), .fast_en(fast_en), .norm_en(norm_en),
        .pclk_en(pclk_en), .pclk_off(pclk_off), .bus_clk_en(bus_clk_en)
    );

    task automatic step(input logic r, input logic s, input logic d,
                        input logic [N-1:0] irq, input logic [N-1:0] fe,
                        input logic [N-1:0] ne, input logic exp_en,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; stop_wr = s; insn_done = d;
        irq_req = irq; fast_en = fe; norm_en = ne;
        e.en = exp_en; e.tag = tag;
        q.push_back(e);
    endtask

    always begin
        exp_t e;
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            n_chk++;
            if (pclk_en !== e.en) begin
                n_fail++;
                $display("FAIL %s: pclk_en=%b expected %b", e.tag, pclk_en, e.en);
            end
            n_chk++;
            if (pclk_off !== !e.en) begin
                n_fail++;
                $display("FAIL R10 (%s): pclk_off=%b expected %b", e.tag, pclk_off, !e.en);
            end
            n_chk++;
            if (bus_clk_en !== 1'b1) begin
                n_fail++;
                $display("FAIL R9: bus_clk_en=%b expected 1", bus_clk_en);
            end
        end
    end

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_up();
    end

    initial begin
        rst = 1; stop_wr = 0; insn_done = 0;
        irq_req = '0; fast_en = '0; norm_en = '0;
        step(1, 0, 0, 8'h00, 8'h00, 8'h00, 1, "R1 reset");
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, "R1 after reset");
        step(0, 1, 0, 8'h00, 8'h00, 8'h00, 1, "R2 drain entry");
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, "R2 draining");
        step(0, 1, 0, 8'h00, 8'h00, 8'h00, 1, "R8 stop in drain");
        step(0, 0, 1, 8'h00, 8'h00, 8'h00, 0, "R3 retire stops");
        step(0, 0, 0, 8'h01, 8'h00, 8'h00, 0, "R5 masked irq");
        step(0, 0, 0, 8'h02, 8'h01, 8'h04, 0, "R5 other source enabled");
        step(0, 1, 0, 8'h00, 8'h00, 8'h00, 0, "R8 stop in idle");
        step(0, 0, 0, 8'h04, 8'h04, 8'h00, 1, "R4 fast wake");
        step(0, 1, 1, 8'h00, 8'h00, 8'h00, 1, "R2 same-cycle retire ignored");
        step(0, 0, 1, 8'h00, 8'h00, 8'h00, 0, "R3 retire stops again");
        step(0, 0, 0, 8'h80, 8'h00, 8'h80, 1, "R4 normal wake");
        step(0, 1, 0, 8'h10, 8'h00, 8'h10, 1, "R7 stop with wake");
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, "R7 still running");
        step(0, 0, 1, 8'h00, 8'h00, 8'h00, 1, "R7 stop dropped");
        step(0, 1, 0, 8'h00, 8'h00, 8'h00, 1, "R2 drain entry 2");
        step(0, 0, 1, 8'h20, 8'h20, 8'h00, 1, "R6 wake beats retire");
        step(0, 0, 1, 8'h00, 8'h00, 8'h00, 1, "R6 stop cancelled");
        step(0, 1, 0, 8'h00, 8'h00, 8'h00, 1, "R2 drain entry 3");
        step(0, 0, 1, 8'h00, 8'h00, 8'h00, 0, "R3 idle again");
        step(1, 0, 0, 8'h00, 8'h00, 8'h00, 1, "R11 reset in idle");
        step(0, 0, 1, 8'h00, 8'h00, 8'h00, 1, "R11 running not draining");
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, "R1 settle");
        repeat (3) @(posedge clk);
        #2;
        finish_up();
    end
endmodule